// File: doc/BRIEF.md
# Packet Buffer MMU Command Engine

This block manages the packet numbers of a shared packet RAM on behalf of a host CPU. It holds a pool of packet numbers, each with an allocated flag. It also holds a transmit queue of numbers waiting to be sent and a completion queue of numbers the transmitter has finished with. The host writes 3-bit command codes and a packet number register (PNR). It reads back a release-in-progress flag, an allocation failure flag, the last allocated number, a sticky release error and the head of the completion queue.

The transmitter side pops the transmit queue when it starts a packet and pushes the packet number into the completion queue when it is done. Most commands finish one cycle after the write. Release commands instead run for a fixed number of cycles with BUSY raised, and during that window the engine refuses further releases. While a release of the PNR's packet runs, the engine also refuses writes to the PNR.

Command codes: 0 no-op, 1 allocate, 2 reset MMU, 3 drop completion head, 4 release completion head, 5 release PNR packet, 6 enqueue PNR, 7 flush both queues.

Top module: `pktmmu_cmd_engine`

## Requirements
- R1: After reset, `busy`, `alloc_failed` and `rel_err` are 0, `pnr_q` and `alloc_result` are 0, and both queues report empty.
- R2: Command 1 puts the lowest-numbered free packet number into `alloc_result`, marks it allocated and clears `alloc_failed`. Both outputs update in the cycle after the command write.
- R3: Command 1 with no free packet number sets `alloc_failed` and leaves `alloc_result` unchanged.
- R4: Command 6 appends `pnr_q` to the transmit queue. `txq_head` presents entries in enqueue order, and `comp_head` presents completion pushes in push order.
- R5: Command 5 on an allocated packet raises `busy` in the cycle after the write and holds it for exactly 4 cycles. The packet named by the PNR is then free and is the next one allocated.
- R6: Commands 4 and 5 that arrive while `busy` is high are ignored and do not extend the busy window.
- R7: A release naming a packet that is not allocated, or a command 4 with an empty completion queue, is ignored: `busy` stays low and the sticky `rel_err` is set.
- R8: Command 4 removes the completion head and releases that packet with the same 4-cycle `busy` window.
- R9: Command 3 removes the completion head without freeing its packet.
- R10: Command 7 empties both queues and leaves every allocation in place.
- R11: Command 2 frees every packet number, empties both queues, clears the PNR and ends any release in progress.
- R12: PNR writes during a command-5 release are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command code |
| pnr_we | input | 1 | PNR write strobe |
| pnr_wdata | input | 3 | PNR write value |
| pnr_q | output | 3 | Current PNR |
| busy | output | 1 | Release in progress |
| alloc_failed | output | 1 | Last allocation found no free number |
| alloc_result | output | 3 | Last allocated packet number |
| rel_err | output | 1 | Sticky invalid-release flag |
| comp_head | output | 3 | Head of completion queue |
| comp_empty | output | 1 | Completion queue empty |
| txq_pop | input | 1 | Transmitter takes the transmit queue head |
| txq_head | output | 3 | Head of transmit queue |
| txq_empty | output | 1 | Transmit queue empty |
| txc_push | input | 1 | Transmitter reports a finished packet |
| txc_pnum | input | 3 | Finished packet number |

## Verification
The registered results `alloc_result`, `alloc_failed`, `rel_err`, `pnr_q` and the queue heads are due one clock edge after the write or pop that causes them. The bench drives each stimulus at a falling edge and samples at the next falling edge, so the single intervening rising edge has taken effect. `busy` is sampled on each of the four cycles after a release command and again on the fifth, where it must be low. An ignored release or PNR write issued inside the window therefore shows up as a window that is too long or as a changed PNR.

// File: rtl/pktmmu_pkg.sv
package pktmmu_pkg;
  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_ALLOC     = 3'd1,
    CMD_RESET_MMU = 3'd2,
    CMD_DROP_DONE = 3'd3,
    CMD_FREE_DONE = 3'd4,
    CMD_FREE_PNR  = 3'd5,
    CMD_ENQUEUE   = 3'd6,
    CMD_FLUSH_TX  = 3'd7
  } mmu_cmd_e;
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          do_push, do_pop;

  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));
  assign head  = mem[rd_ptr_q];

  always_comb begin
    do_pop   = pop && !empty && !flush;
    do_push  = push && (!full || do_pop) && !flush;
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    count_d  = count_q;
    if (flush) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_pop)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      if (do_push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_push && !do_pop) count_d = count_q + 1'b1;
      else if (do_pop && !do_push) count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  // R10: a flush leaves the queue empty on the next cycle
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R4: a push into a full queue without a pop is dropped
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/pkt_pool.sv
module pkt_pool #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          alloc_req,
  input  logic          free_req,
  input  logic [IW-1:0] free_idx,
  output logic          alloc_ok,
  output logic [IW-1:0] alloc_idx,
  output logic [N-1:0]  used_map
);
  logic [N-1:0] map_q, map_d;

  assign used_map = map_q;

  always_comb begin
    alloc_ok  = 1'b0;
    alloc_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (!map_q[i]) begin
        alloc_ok  = 1'b1;
        alloc_idx = IW'(i);
      end
    end
  end

  always_comb begin
    map_d = map_q;
    if (clr_all) begin
      map_d = '0;
    end else begin
      if (alloc_req && alloc_ok) map_d[alloc_idx] = 1'b1;
      if (free_req)              map_d[free_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  // R2: a granted number is marked allocated
  p_alloc_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ok && !clr_all) |=> map_q[$past(alloc_idx)]);
  // R5: a completed release frees its number
  p_free_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_req && !clr_all) |=> !map_q[$past(free_idx)]);
endmodule

// File: rtl/pktmmu_cmd_engine.sv
module pktmmu_cmd_engine
  import pktmmu_pkg::*;
#(
  parameter int NUM_PKTS       = 8,
  parameter int FIFO_DEPTH     = 8,
  parameter int RELEASE_CYCLES = 4,
  localparam int PKT_W         = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic             pnr_we,
  input  logic [PKT_W-1:0] pnr_wdata,
  output logic [PKT_W-1:0] pnr_q,
  output logic             busy,
  output logic             alloc_failed,
  output logic [PKT_W-1:0] alloc_result,
  output logic             rel_err,
  output logic [PKT_W-1:0] comp_head,
  output logic             comp_empty,
  input  logic             txq_pop,
  output logic [PKT_W-1:0] txq_head,
  output logic             txq_empty,
  input  logic             txc_push,
  input  logic [PKT_W-1:0] txc_pnum
);
  localparam int CNT_W = $clog2(RELEASE_CYCLES + 1);

  mmu_cmd_e         cmd;
  logic             is_alloc, is_rst, is_drop, is_free_done, is_free_pnr, is_enq, is_flush;
  logic             start4, start5, bad_rel, rel_done, comp_pop;
  logic             busy_q, busy_d, src_pnr_q, src_pnr_d, err_q, err_d, fail_q, fail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PKT_W-1:0] rel_idx_q, rel_idx_d, pnr_d, res_q, res_d;
  logic             alloc_ok, comp_full, txq_full;
  logic [PKT_W-1:0] alloc_idx;
  logic [NUM_PKTS-1:0] used_map;

  assign cmd = mmu_cmd_e'(cmd_code);

  always_comb begin
    is_alloc     = cmd_valid && (cmd == CMD_ALLOC);
    is_rst       = cmd_valid && (cmd == CMD_RESET_MMU);
    is_drop      = cmd_valid && (cmd == CMD_DROP_DONE);
    is_free_done = cmd_valid && (cmd == CMD_FREE_DONE);
    is_free_pnr  = cmd_valid && (cmd == CMD_FREE_PNR);
    is_enq       = cmd_valid && (cmd == CMD_ENQUEUE);
    is_flush     = cmd_valid && (cmd == CMD_FLUSH_TX);
    start5   = is_free_pnr && !busy_q && used_map[pnr_q];
    start4   = is_free_done && !busy_q && !comp_empty && used_map[comp_head];
    bad_rel  = !busy_q && ((is_free_pnr && !used_map[pnr_q]) ||
                           (is_free_done && (comp_empty || !used_map[comp_head])));
    rel_done = busy_q && (cnt_q == '0);
    comp_pop = is_drop || start4;
  end

  always_comb begin
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    rel_idx_d = rel_idx_q;
    src_pnr_d = src_pnr_q;
    if (is_rst) begin
      busy_d = 1'b0;
    end else if (start4 || start5) begin
      busy_d    = 1'b1;
      cnt_d     = CNT_W'(RELEASE_CYCLES - 1);
      rel_idx_d = start5 ? pnr_q : comp_head;
      src_pnr_d = start5;
    end else if (rel_done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end

    pnr_d = pnr_q;
    if (is_rst) pnr_d = '0;
    else if (pnr_we && !(busy_q && src_pnr_q)) pnr_d = pnr_wdata;

    res_d  = res_q;
    fail_d = fail_q;
    if (is_alloc) begin
      fail_d = !alloc_ok;
      if (alloc_ok) res_d = alloc_idx;
    end

    err_d = err_q || bad_rel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      rel_idx_q <= '0;
      src_pnr_q <= 1'b0;
      pnr_q     <= '0;
      res_q     <= '0;
      fail_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      cnt_q     <= cnt_d;
      rel_idx_q <= rel_idx_d;
      src_pnr_q <= src_pnr_d;
      pnr_q     <= pnr_d;
      res_q     <= res_d;
      fail_q    <= fail_d;
      err_q     <= err_d;
    end
  end

  assign busy         = busy_q;
  assign alloc_failed = fail_q;
  assign alloc_result = res_q;
  assign rel_err      = err_q;

  pkt_pool #(.N(NUM_PKTS), .IW(PKT_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .clr_all(is_rst), .alloc_req(is_alloc),
    .free_req(rel_done && !is_rst), .free_idx(rel_idx_q),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .used_map(used_map));

  pkt_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(is_flush || is_rst), .push(is_enq),
    .push_data(pnr_q), .pop(txq_pop), .head(txq_head), .empty(txq_empty),
    .full(txq_full));

  pkt_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_compq (
    .clk(clk), .rst_n(rst_n), .flush(is_flush || is_rst), .push(txc_push),
    .push_data(txc_pnum), .pop(comp_pop), .head(comp_head), .empty(comp_empty),
    .full(comp_full));

  // R5: busy only rises after a release command write
  p_busy_from_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_valid) &&
      ($past(cmd_code) == 3'd4 || $past(cmd_code) == 3'd5)));
  // R6: a release during busy does not reload the window
  p_busy_ignores_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && cmd_valid && (cmd_code == 3'd4 || cmd_code == 3'd5))
      |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  // R12: PNR held while a command-5 release runs
  p_pnr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && src_pnr_q && !is_rst) |=> $stable(pnr_q));
  // R3: failed allocation keeps the previous result
  p_fail_keeps_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_alloc && !alloc_ok) |=> (alloc_failed && $stable(alloc_result)));
  // R7: the release error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err);
  // R10: flushing the queues leaves the pool alone
  p_flush_keeps_pool_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_flush && !rel_done) |=> (used_map == $past(used_map)));
endmodule

// File: tb/pktmmu_cmd_engine_tb.sv
module pktmmu_cmd_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, pnr_we, txq_pop, txc_push;
  logic [2:0] cmd_code, pnr_wdata, txc_pnum;
  logic [2:0] pnr_q, alloc_result, comp_head, txq_head;
  logic       busy, alloc_failed, rel_err, comp_empty, txq_empty;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pktmmu_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .pnr_q(pnr_q), .busy(busy),
    .alloc_failed(alloc_failed), .alloc_result(alloc_result), .rel_err(rel_err),
    .comp_head(comp_head), .comp_empty(comp_empty), .txq_pop(txq_pop),
    .txq_head(txq_head), .txq_empty(txq_empty), .txc_push(txc_push),
    .txc_pnum(txc_pnum));

  // allocation vectors: {expected result, expected failed}
  localparam logic [3:0] ALLOC_TBL [10] = '{
    {3'd0,1'b0}, {3'd1,1'b0}, {3'd2,1'b0}, {3'd3,1'b0}, {3'd4,1'b0},
    {3'd5,1'b0}, {3'd6,1'b0}, {3'd7,1'b0}, {3'd7,1'b1}, {3'd7,1'b1}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0;
  endtask

  task automatic set_pnr(input logic [2:0] v);
    pnr_we = 1'b1; pnr_wdata = v;
    @(negedge clk);
    pnr_we = 1'b0;
  endtask

  task automatic tx_pop();
    txq_pop = 1'b1;
    @(negedge clk);
    txq_pop = 1'b0;
  endtask

  task automatic tx_push(input logic [2:0] v);
    txc_push = 1'b1; txc_pnum = v;
    @(negedge clk);
    txc_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = '0; pnr_we = 1'b0; pnr_wdata = '0;
    txq_pop = 1'b0; txc_push = 1'b0; txc_pnum = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy", busy, 0);
    chk("R1 failed", alloc_failed, 0);
    chk("R1 rel_err", rel_err, 0);
    chk("R1 pnr", pnr_q, 0);
    chk("R1 result", alloc_result, 0);
    chk("R1 txq_empty", txq_empty, 1);
    chk("R1 comp_empty", comp_empty, 1);

    // R2 / R3 table walk: allocate until the pool runs dry
    for (int i = 0; i < 10; i++) begin
      do_cmd(3'd1);
      chk(i < 8 ? "R2 result" : "R3 result", alloc_result, ALLOC_TBL[i][3:1]);
      chk(i < 8 ? "R2 failed" : "R3 failed", alloc_failed, ALLOC_TBL[i][0]);
    end

    // R4 ordering
    set_pnr(3'd2); do_cmd(3'd6);
    set_pnr(3'd5); do_cmd(3'd6);
    set_pnr(3'd1); do_cmd(3'd6);
    chk("R4 txq head first", txq_head, 2);
    tx_pop();
    chk("R4 txq head second", txq_head, 5);
    tx_push(3'd2); tx_push(3'd5);
    chk("R4 comp head first", comp_head, 2);
    tx_pop();
    chk("R4 txq head third", txq_head, 1);
    tx_pop();
    chk("R4 txq drained", txq_empty, 1);
    // R9 drop without free
    do_cmd(3'd3);
    chk("R9 comp head advanced", comp_head, 5);
    do_cmd(3'd1);
    chk("R9 pool still full", alloc_failed, 1);

    // R10 flush while allocated
    set_pnr(3'd7); do_cmd(3'd6); tx_push(3'd7);
    do_cmd(3'd7);
    chk("R10 txq empty", txq_empty, 1);
    chk("R10 comp empty", comp_empty, 1);
    do_cmd(3'd1);
    chk("R10 allocations kept", alloc_failed, 1);
    chk("R10 result kept", alloc_result, 7);

    // R5 / R6 / R12 release window
    set_pnr(3'd3);
    do_cmd(3'd5);
    chk("R5 busy cycle1", busy, 1);
    set_pnr(3'd6);
    chk("R12 pnr held", pnr_q, 3);
    chk("R5 busy cycle2", busy, 1);
    do_cmd(3'd5);
    chk("R6 busy cycle3", busy, 1);
    @(negedge clk);
    chk("R5 busy cycle4", busy, 1);
    @(negedge clk);
    chk("R6 busy ends after 4", busy, 0);
    do_cmd(3'd1);
    chk("R5 freed number reused", alloc_result, 3);
    chk("R5 failed cleared", alloc_failed, 0);
    chk("R7 no error on valid release", rel_err, 0);

    // R8 release completion head
    tx_push(3'd4);
    do_cmd(3'd4);
    chk("R8 busy", busy, 1);
    chk("R8 head removed", comp_empty, 1);
    repeat (3) @(negedge clk);
    chk("R8 busy cycle4", busy, 1);
    @(negedge clk);
    chk("R8 busy done", busy, 0);
    do_cmd(3'd1);
    chk("R8 freed number reused", alloc_result, 4);

    // R11 reset MMU
    set_pnr(3'd5); do_cmd(3'd6); tx_push(3'd1);
    do_cmd(3'd2);
    chk("R11 pnr cleared", pnr_q, 0);
    chk("R11 txq empty", txq_empty, 1);
    chk("R11 comp empty", comp_empty, 1);
    chk("R11 busy low", busy, 0);
    do_cmd(3'd1);
    chk("R11 pool freed first", alloc_result, 0);
    do_cmd(3'd1);
    chk("R11 pool freed second", alloc_result, 1);

    // R7 invalid releases
    do_cmd(3'd4);
    chk("R7 empty completion no busy", busy, 0);
    chk("R7 error set", rel_err, 1);
    set_pnr(3'd6);
    do_cmd(3'd5);
    chk("R7 unallocated no busy", busy, 0);
    do_cmd(3'd1);
    chk("R7 pool untouched", alloc_result, 2);
    chk("R7 error sticky", rel_err, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule